// File: doc/BRIEF.md
# Banked GPIO Controller with Atomic Register Aliases

This block drives and samples the general-purpose pins of a chip in banks of up to 32 pins. For each bank it holds the output value, the output-enable mask, an interrupt-source mask, an interrupt-enable mask, two mode registers and the interrupt-status register. It also returns the synchronized pin levels. A host reaches every register over a simple 32-bit bus with one write strobe and a combinational read port.

Each register answers at four word addresses. Software can replace it, set bits, clear bits or invert bits in one bus write, so no read-modify-write is needed and no update is lost. Each pin has its own interrupt detector. The detector can be set for rising edge, falling edge, high level or low level. Each bank raises its own interrupt line while any enabled status bit is set.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register in every bank reads zero, `pad_oe` and `pad_out` are all zero and every `irq` bit is low.
- R2: Address bits [15:8] pick the register group: output value 0x07, pin level 0x09, output enable 0x0B, interrupt source 0x10, interrupt enable 0x11, mode level 0x12, mode polarity 0x13, status 0x14. Address bits [7:4] pick the bank, and bits [3:2] pick the alias. A read at any alias of a register returns that register.
- R3: A write with alias bits 0 (offset +0x0) replaces the whole register with the write data.
- R4: A write with alias bits 1 (offset +0x4) sets every register bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: A write with alias bits 2 (offset +0x8) clears every register bit whose write-data bit is 1 and leaves the other bits unchanged.
- R6: A write with alias bits 3 (offset +0xC) inverts every register bit whose write-data bit is 1 and leaves the other bits unchanged.
- R7: `pad_out` carries each bank's output-value register. `pad_oe` carries its output-enable register. An enable bit of 1 drives the pin, and 0 releases it to high impedance.
- R8: Reading the pin-level group returns `pad_in` after a two-flop synchronizer. A change shows on the read after two rising edges and not after one. Writes to this group change nothing.
- R9: A pin's mode is {polarity bit, level bit}: 0 = falling edge, 1 = low level, 2 = rising edge, 3 = high level. In an edge mode, one synchronized transition sets the status bit once. After a clear the bit stays 0 until the next transition.
- R10: In a level mode the status bit is set on every cycle the synchronized pin matches the polarity. A clear done while the level holds leaves the bit at 1, because the hardware set takes precedence over the clear.
- R11: Hardware sets a status bit only when that pin's interrupt-source bit is 1.
- R12: `irq[n]` is high exactly when bank n has at least one pin whose status and enable bits are both 1.
- R13: An address outside the groups, with bank field ≥ NUM_BANKS, or with bits [1:0] ≠ 0, reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Write strobe, one write per cycle |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Combinational read data for `cpu_addr` |
| pad_in | input | NUM_BANKS*PINS | Pin levels, bank n at bits [n*PINS +: PINS] |
| pad_out | output | NUM_BANKS*PINS | Output values |
| pad_oe | output | NUM_BANKS*PINS | Output enables, 1 = drive |
| irq | output | NUM_BANKS | Per-bank interrupt |

## Verification
The bench builds the block with its default parameters: five banks of 32 pins. With these values it can write the highest bank (bank 4) and also hit bank field 5, which lies just past the end and must read as zero. Full 32-bit patterns exercise bit 31 of every alias. All four interrupt modes, the source gate and the enable gate are tested on one pin. The checks sample at the synchronizer depth, so they show both the one-edge and the two-edge timing.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 16;

    // register group base addresses
    localparam logic [ADDR_W-1:0] OFS_DOUT = 16'h0700;
    localparam logic [ADDR_W-1:0] OFS_DIN  = 16'h0900;
    localparam logic [ADDR_W-1:0] OFS_OE   = 16'h0B00;
    localparam logic [ADDR_W-1:0] OFS_SEL  = 16'h1000;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 16'h1100;
    localparam logic [ADDR_W-1:0] OFS_LVL  = 16'h1200;
    localparam logic [ADDR_W-1:0] OFS_POL  = 16'h1300;
    localparam logic [ADDR_W-1:0] OFS_STAT = 16'h1400;

    typedef enum logic [3:0] {
        GRP_NONE, GRP_DOUT, GRP_DIN, GRP_OE, GRP_SEL,
        GRP_IEN, GRP_LVL, GRP_POL, GRP_STAT
    } grp_e;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_SET    = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_TOGGLE = 2'd3
    } op_e;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec import gpio_pkg::*; #(
    parameter int NUM_BANKS = 5
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              valid_o,
    output grp_e              grp_o,
    output logic [3:0]        bank_o,
    output op_e               op_o
);

    grp_e grp_raw;

    always_comb begin
        case (addr_i[15:8])
            OFS_DOUT[15:8]: grp_raw = GRP_DOUT;
            OFS_DIN[15:8]:  grp_raw = GRP_DIN;
            OFS_OE[15:8]:   grp_raw = GRP_OE;
            OFS_SEL[15:8]:  grp_raw = GRP_SEL;
            OFS_IEN[15:8]:  grp_raw = GRP_IEN;
            OFS_LVL[15:8]:  grp_raw = GRP_LVL;
            OFS_POL[15:8]:  grp_raw = GRP_POL;
            OFS_STAT[15:8]: grp_raw = GRP_STAT;
            default:        grp_raw = GRP_NONE;
        endcase
    end

    always_comb begin
        bank_o  = addr_i[7:4];
        op_o    = op_e'(addr_i[3:2]);
        valid_o = (grp_raw != GRP_NONE) && (int'(addr_i[7:4]) < NUM_BANKS)
                  && (addr_i[1:0] == 2'b00);
        grp_o   = valid_o ? grp_raw : GRP_NONE;
    end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = d_i;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign q_o = sy_q.s2;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank import gpio_pkg::*; #(
    parameter int PINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  grp_e             grp,
    input  op_e              op,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rd_data,
    input  logic [PINS-1:0]  pad_in,
    output logic [PINS-1:0]  pad_out,
    output logic [PINS-1:0]  pad_oe,
    output logic             irq
);

    typedef struct packed {
        logic [PINS-1:0] dout;
        logic [PINS-1:0] oe;
        logic [PINS-1:0] sel;
        logic [PINS-1:0] ien;
        logic [PINS-1:0] lvl;
        logic [PINS-1:0] pol;
        logic [PINS-1:0] stat;
        logic [PINS-1:0] prev;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [PINS-1:0] pin_s;
    logic [PINS-1:0] wd;
    logic [PINS-1:0] rise, fall, hit_lvl, hit_edge, hw_set, lvl_hold;

    function automatic logic [PINS-1:0] upd(input logic [PINS-1:0] cur,
                                            input op_e o,
                                            input logic [PINS-1:0] m);
        case (o)
            OP_SET:    return cur | m;
            OP_CLEAR:  return cur & ~m;
            OP_TOGGLE: return cur ^ m;
            default:   return m;
        endcase
    endfunction

    gpio_sync #(.W(PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pad_in),
        .q_o   (pin_s)
    );

    assign wd = wdata[PINS-1:0];

    always_comb begin
        rise     = pin_s & ~st_q.prev;
        fall     = ~pin_s & st_q.prev;
        hit_lvl  = st_q.lvl & ~(pin_s ^ st_q.pol);
        hit_edge = ~st_q.lvl & ((st_q.pol & rise) | (~st_q.pol & fall));
        hw_set   = st_q.sel & (hit_lvl | hit_edge);
        lvl_hold = st_q.sel & hit_lvl;

        st_d      = st_q;
        st_d.prev = pin_s;
        if (wr_en) begin
            case (grp)
                GRP_DOUT: st_d.dout = upd(st_q.dout, op, wd);
                GRP_OE:   st_d.oe   = upd(st_q.oe,   op, wd);
                GRP_SEL:  st_d.sel  = upd(st_q.sel,  op, wd);
                GRP_IEN:  st_d.ien  = upd(st_q.ien,  op, wd);
                GRP_LVL:  st_d.lvl  = upd(st_q.lvl,  op, wd);
                GRP_POL:  st_d.pol  = upd(st_q.pol,  op, wd);
                GRP_STAT: st_d.stat = upd(st_q.stat, op, wd);
                default:  ;
            endcase
        end
        // hardware detection wins over a software clear in the same cycle
        st_d.stat = st_d.stat | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        case (grp)
            GRP_DOUT: rd_data[PINS-1:0] = st_q.dout;
            GRP_DIN:  rd_data[PINS-1:0] = pin_s;
            GRP_OE:   rd_data[PINS-1:0] = st_q.oe;
            GRP_SEL:  rd_data[PINS-1:0] = st_q.sel;
            GRP_IEN:  rd_data[PINS-1:0] = st_q.ien;
            GRP_LVL:  rd_data[PINS-1:0] = st_q.lvl;
            GRP_POL:  rd_data[PINS-1:0] = st_q.pol;
            GRP_STAT: rd_data[PINS-1:0] = st_q.stat;
            default:  rd_data = '0;
        endcase
    end

    assign pad_out = st_q.dout;
    assign pad_oe  = st_q.oe;
    assign irq     = |(st_q.stat & st_q.ien);

    // R5
    clear_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && grp == GRP_DOUT && op == OP_CLEAR) |=> ((pad_out & $past(wd)) == '0));

    // R4
    set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && grp == GRP_OE && op == OP_SET) |=> ((pad_oe & $past(wd)) == $past(wd)));

    // R13
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && grp == GRP_DOUT) |=> $stable(pad_out));

    // R11
    src_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && grp == GRP_STAT) |=> ((st_q.stat & ~$past(st_q.stat) & ~$past(st_q.sel)) == '0));

    // R10
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_hold != '0) |=> ((st_q.stat & $past(lvl_hold)) == $past(lvl_hold)));

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl import gpio_pkg::*; #(
    parameter int NUM_BANKS = 5,
    parameter int PINS      = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_we,
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic [BUS_W-1:0]          cpu_wdata,
    output logic [BUS_W-1:0]          cpu_rdata,
    input  logic [NUM_BANKS*PINS-1:0] pad_in,
    output logic [NUM_BANKS*PINS-1:0] pad_out,
    output logic [NUM_BANKS*PINS-1:0] pad_oe,
    output logic [NUM_BANKS-1:0]      irq
);

    logic       dec_valid;
    grp_e       dec_grp;
    logic [3:0] dec_bank;
    op_e        dec_op;

    logic [NUM_BANKS-1:0] bank_we;
    logic [BUS_W-1:0]     bank_rd [NUM_BANKS];

    gpio_addr_dec #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .addr_i  (cpu_addr),
        .valid_o (dec_valid),
        .grp_o   (dec_grp),
        .bank_o  (dec_bank),
        .op_o    (dec_op)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_we[b] = cpu_we && dec_valid && (int'(dec_bank) == b);

        gpio_bank #(.PINS(PINS)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_we[b]),
            .grp     (dec_grp),
            .op      (dec_op),
            .wdata   (cpu_wdata),
            .rd_data (bank_rd[b]),
            .pad_in  (pad_in[b*PINS +: PINS]),
            .pad_out (pad_out[b*PINS +: PINS]),
            .pad_oe  (pad_oe[b*PINS +: PINS]),
            .irq     (irq[b])
        );
    end

    always_comb begin
        cpu_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (dec_valid && int'(dec_bank) == b) cpu_rdata = bank_rd[b];
        end
    end

    // R2
    one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));

endmodule

// File: tb/tb_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_bank_ctrl;

    localparam int NB = 5;
    localparam int PW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_we = 1'b0;
    logic [15:0]       cpu_addr = '0;
    logic [31:0]       cpu_wdata = '0;
    logic [31:0]       cpu_rdata;
    logic [NB*PW-1:0]  pad_in = '0;
    logic [NB*PW-1:0]  pad_out;
    logic [NB*PW-1:0]  pad_oe;
    logic [NB-1:0]     irq;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    gpio_bank_ctrl #(.NUM_BANKS(NB), .PINS(PW)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    typedef struct packed {
        logic [15:0] waddr;
        logic [31:0] wdata;
        logic [15:0] raddr;
        logic [31:0] expd;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{16'h0700, 32'h12345678, 16'h0700, 32'h12345678, 8'd3},  // R3
        '{16'h0704, 32'h0000000F, 16'h0700, 32'h1234567F, 8'd4},  // R4
        '{16'h0708, 32'h12000000, 16'h0700, 32'h0034567F, 8'd5},  // R5
        '{16'h070C, 32'hFF000000, 16'h0700, 32'hFF34567F, 8'd6},  // R6
        '{16'h0740, 32'hCAFEF00D, 16'h0740, 32'hCAFEF00D, 8'd2},  // R2 top bank
        '{16'h0710, 32'h00000001, 16'h0710, 32'h00000001, 8'd2},  // R2
        '{16'h0B20, 32'h0000FFFF, 16'h0B20, 32'h0000FFFF, 8'd3},  // R3
        '{16'h0B24, 32'hFFFF0000, 16'h0B20, 32'hFFFFFFFF, 8'd4},  // R4
        '{16'h0B28, 32'h0000000F, 16'h0B20, 32'hFFFFFFF0, 8'd5},  // R5
        '{16'h0800, 32'hFFFFFFFF, 16'h0800, 32'h00000000, 8'd13}, // R13 no group
        '{16'h0750, 32'hFFFFFFFF, 16'h0750, 32'h00000000, 8'd13}, // R13 bank 5
        '{16'h0702, 32'hFFFFFFFF, 16'h0700, 32'hFF34567F, 8'd13}, // R13 misaligned
        '{16'h0900, 32'hFFFFFFFF, 16'h0900, 32'h00000000, 8'd8},  // R8 write ignored
        '{16'h1030, 32'h00000003, 16'h1030, 32'h00000003, 8'd3},  // R3
        '{16'h121C, 32'h00000001, 16'h1218, 32'h00000001, 8'd6}   // R6, R2 alias read
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        n_run++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cpu_we    = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [31:0] d);
        cpu_addr = a;
        #1;
        d = cpu_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a, input logic [31:0] exp_v);
        logic [31:0] v;
        bus_rd(a, v);
        check(tag, v, exp_v);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        rd_chk("R1 dout", 16'h0700, 32'h0);
        rd_chk("R1 oe", 16'h0B40, 32'h0);
        rd_chk("R1 stat", 16'h1420, 32'h0);
        rd_chk("R1 mode", 16'h1230, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 pad_oe", 32'(|pad_oe), 32'h0);
        check("R1 pad_out", 32'(|pad_out), 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            bus_wr(VECS[i].waddr, VECS[i].wdata);
            bus_rd(VECS[i].raddr, v);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].expd);
        end

        // R7 pins follow registers
        check("R7 pad_oe bank2", pad_oe[2*PW +: PW], 32'hFFFFFFF0);
        check("R7 pad_out bank0", pad_out[0 +: PW], 32'hFF34567F);
        check("R7 pad_out bank4", pad_out[4*PW +: PW], 32'hCAFEF00D);
        check("R7 pad_oe bank0", pad_oe[0 +: PW], 32'h0);

        // R8 synchronizer depth
        pad_in[PW +: PW] = 32'h80000001;
        step(1);
        rd_chk("R8 one edge", 16'h0910, 32'h0);
        step(1);
        rd_chk("R8 two edges", 16'h0910, 32'h80000001);

        // R11 source gate: rising mode, enabled, source off
        bus_wr(16'h1104, 32'h1);
        bus_wr(16'h1304, 32'h1);
        pad_in[0] = 1'b1;
        step(4);
        rd_chk("R11 no source", 16'h1400, 32'h0);
        check("R12 irq idle", 32'(irq), 32'h0);

        // R9 rising edge
        pad_in[0] = 1'b0;
        step(4);
        bus_wr(16'h1004, 32'h1);
        pad_in[0] = 1'b1;
        step(4);
        rd_chk("R9 rising set", 16'h1400, 32'h1);
        check("R12 irq raised", 32'(irq), 32'h1);
        bus_wr(16'h1408, 32'h1);
        rd_chk("R9 rising once", 16'h1400, 32'h0);
        check("R12 irq dropped", 32'(irq), 32'h0);

        // R9 falling edge
        bus_wr(16'h1308, 32'h1);
        pad_in[0] = 1'b0;
        step(4);
        rd_chk("R9 falling set", 16'h1400, 32'h1);
        bus_wr(16'h1408, 32'h1);
        rd_chk("R9 falling clear", 16'h1400, 32'h0);

        // R10 high level
        bus_wr(16'h1304, 32'h1);
        bus_wr(16'h1204, 32'h1);
        rd_chk("R10 high idle", 16'h1400, 32'h0);
        pad_in[0] = 1'b1;
        step(4);
        rd_chk("R10 high set", 16'h1400, 32'h1);
        bus_wr(16'h1408, 32'h1);
        rd_chk("R10 clear while held", 16'h1400, 32'h1);
        pad_in[0] = 1'b0;
        step(4);
        bus_wr(16'h1408, 32'h1);
        rd_chk("R10 clear after release", 16'h1400, 32'h0);

        // R9 low level
        bus_wr(16'h1308, 32'h1);
        step(2);
        rd_chk("R9 low level set", 16'h1400, 32'h1);
        pad_in[0] = 1'b1;
        step(4);
        bus_wr(16'h1408, 32'h1);
        rd_chk("R9 low level clear", 16'h1400, 32'h0);

        // R12 enable gate
        bus_wr(16'h1108, 32'h1);
        pad_in[0] = 1'b0;
        step(4);
        rd_chk("R12 status without enable", 16'h1400, 32'h1);
        check("R12 irq masked", 32'(irq), 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule